// File: doc/BRIEF.md
# Pipelined Byte-Writable Synchronous RAM

This block is a single-port synchronous RAM holding words of four 8-bit byte lanes. Every request (chip select, address, write data, per-lane enables, byte-mode write enable and global write) is captured in one input register stage on the rising clock edge. On the next edge the stored request either commits a self-timed write into the array or loads the addressed word into an output register. No externally shaped write pulse is needed.

Three controls decide which lanes a write touches. A lane is written when its own enable and the byte-mode write enable are both set. The global write input forces all four lanes regardless of the lane enables. Read data leaves through the output register, and an unregistered output enable gates the port. When the port is not driving, the data output sits at zero and a drive flag marks it idle, standing in for high impedance. The number of words is a parameter.

Top module: `pbw_sram`

## Requirements
- R1: After reset, `rdata` is 0 and `rdata_oe` is 0 until a read has passed through the pipeline.
- R2: A write commits byte lane i (bits 8i+7..8i; lane a is i=0, lane d is i=3) only when `sel`, `bw_en` and `lane_en[i]` were all 1 at the sampling edge.
- R3: When `sel` and `gw_en` are sampled 1, all four lanes are written whatever `lane_en` and `bw_en` hold.
- R4: With `sel`, `bw_en` and all four `lane_en` bits set, the whole word is written.
- R5: A read (`sel`=1, `gw_en`=0, `bw_en`=0) sampled at edge k drives the stored word on `rdata` with `rdata_oe`=1 from edge k+1 until edge k+2.
- R6: A read sampled on the edge right after a write to the same address returns the newly written bytes.
- R7: `oe` acts without a clock. While `oe` is 0, `rdata` is 0 and `rdata_oe` is 0 within the same cycle.
- R8: A cycle sampled with `sel`=0, or a write cycle, leaves the port not driving (`rdata_oe`=0) from the next edge on.
- R9: Lanes that a write does not enable keep their previous contents.
- R10: With `sel`=0, no lane is written, even with `gw_en` or `bw_en` set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the control registers |
| sel | input | 1 | Chip select, sampled |
| addr | input | ADDR_W | Word address, sampled |
| wdata | input | 32 | Write data, sampled |
| lane_en | input | 4 | Per-lane enables, bit i for lane i, sampled |
| bw_en | input | 1 | Byte-mode write enable, sampled |
| gw_en | input | 1 | Global write, all lanes, sampled |
| oe | input | 1 | Asynchronous output enable |
| rdata | output | 32 | Read data, 0 when not driving |
| rdata_oe | output | 1 | 1 while the port drives `rdata` |

## Verification
On a single clock edge, a write held in the input stage commits to the array while the request behind it is captured. When that next request reads the same address, the write commit and the read fetch meet in one cycle. The bench provokes this with back-to-back write-then-read pairs to one address, using global, partial-lane and all-lane writes. The returned word is judged against a bench memory model that applies the earlier write before serving the later read.

// File: rtl/pbw_pkg.sv
package pbw_pkg;
    localparam int unsigned LANES  = 4;
    localparam int unsigned LANE_W = 8;
    localparam int unsigned WORD_W = LANES * LANE_W;

    typedef logic [LANES-1:0]  lane_mask_t;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/pbw_in_stage.sv
module pbw_in_stage
    import pbw_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  word_t             wdata_i,
    input  lane_mask_t        lane_en_i,
    input  logic              bw_en_i,
    input  logic              gw_en_i,
    output logic              sel_o,
    output logic [ADDR_W-1:0] addr_o,
    output word_t             wdata_o,
    output lane_mask_t        lane_en_o,
    output logic              bw_en_o,
    output logic              gw_en_o
);
    typedef struct packed {
        logic              sel;
        logic [ADDR_W-1:0] addr;
        word_t             wdata;
        lane_mask_t        lane_en;
        logic              bw_en;
        logic              gw_en;
    } req_t;

    req_t req_d, req_q;

    always_comb begin
        req_d.sel     = sel_i;
        req_d.addr    = addr_i;
        req_d.wdata   = wdata_i;
        req_d.lane_en = lane_en_i;
        req_d.bw_en   = bw_en_i;
        req_d.gw_en   = gw_en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end

    assign sel_o     = req_q.sel;
    assign addr_o    = req_q.addr;
    assign wdata_o   = req_q.wdata;
    assign lane_en_o = req_q.lane_en;
    assign bw_en_o   = req_q.bw_en;
    assign gw_en_o   = req_q.gw_en;
endmodule

// File: rtl/pbw_lane_dec.sv
module pbw_lane_dec
    import pbw_pkg::*;
(
    input  logic       sel_i,
    input  logic       bw_en_i,
    input  logic       gw_en_i,
    input  lane_mask_t lane_en_i,
    output lane_mask_t lane_we_o,
    output logic       rd_o
);
    logic       wr_cycle;
    lane_mask_t mask;

    always_comb begin
        wr_cycle = sel_i & (gw_en_i | bw_en_i);
        if (gw_en_i) begin
            mask = '1;
        end else if (bw_en_i) begin
            mask = lane_en_i;
        end else begin
            mask = '0;
        end
        lane_we_o = wr_cycle ? mask : '0;
        rd_o      = sel_i & ~wr_cycle;
    end
endmodule

// File: rtl/pbw_array.sv
module pbw_array
    import pbw_pkg::*;
#(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  lane_mask_t        lane_we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  word_t             wdata_i,
    output word_t             rdata_o
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we_i[l]) begin
                mem_q[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
            end
        end

        assign rdata_o[l*LANE_W +: LANE_W] = mem_q[addr_i];
    end
endmodule

// File: rtl/pbw_out_stage.sv
module pbw_out_stage
    import pbw_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rd_i,
    input  word_t fetch_i,
    input  logic  oe_i,
    output word_t rdata_o,
    output logic  drive_o
);
    typedef struct packed {
        logic  drive;
        word_t data;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d       = out_q;
        out_d.drive = rd_i;
        if (rd_i) begin
            out_d.data = fetch_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign drive_o = oe_i & out_q.drive;
    assign rdata_o = drive_o ? out_q.data : '0;

    // R7
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_i |-> (rdata_o == '0 && !drive_o));

    // R8
    drive_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> !drive_o);
endmodule

// File: rtl/pbw_sram.sv
module pbw_sram
    import pbw_pkg::*;
#(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [3:0]        lane_en,
    input  logic              bw_en,
    input  logic              gw_en,
    input  logic              oe,
    output logic [31:0]       rdata,
    output logic              rdata_oe
);
    logic              sel_q;
    logic [ADDR_W-1:0] addr_q;
    word_t             wdata_q;
    lane_mask_t        lane_en_q;
    logic              bw_en_q;
    logic              gw_en_q;
    lane_mask_t        lane_we;
    logic              rd_req;
    word_t             fetch;

    pbw_in_stage #(.ADDR_W(ADDR_W)) u_in (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (sel),
        .addr_i   (addr),
        .wdata_i  (wdata),
        .lane_en_i(lane_en),
        .bw_en_i  (bw_en),
        .gw_en_i  (gw_en),
        .sel_o    (sel_q),
        .addr_o   (addr_q),
        .wdata_o  (wdata_q),
        .lane_en_o(lane_en_q),
        .bw_en_o  (bw_en_q),
        .gw_en_o  (gw_en_q)
    );

    pbw_lane_dec u_dec (
        .sel_i    (sel_q),
        .bw_en_i  (bw_en_q),
        .gw_en_i  (gw_en_q),
        .lane_en_i(lane_en_q),
        .lane_we_o(lane_we),
        .rd_o     (rd_req)
    );

    pbw_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
        .clk      (clk),
        .lane_we_i(lane_we),
        .addr_i   (addr_q),
        .wdata_i  (wdata_q),
        .rdata_o  (fetch)
    );

    pbw_out_stage u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_i   (rd_req),
        .fetch_i(fetch),
        .oe_i   (oe),
        .rdata_o(rdata),
        .drive_o(rdata_oe)
    );

    // R10
    desel_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!sel) |-> (lane_we == '0));

    // R3
    global_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel && gw_en) |-> (lane_we == '1));

    // R2
    byte_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel && !gw_en && bw_en) |-> (lane_we == $past(lane_en)));

    // R8
    wr_nodrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q && (gw_en_q || bw_en_q)) |=> !rdata_oe);
endmodule

// File: tb/pbw_sram_tb.sv
`timescale 1ns/1ps
module pbw_sram_tb;
    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  lane_en = '0;
    logic        bw_en = 1'b0;
    logic        gw_en = 1'b0;
    logic        oe = 1'b1;
    logic [31:0] rdata;
    logic        rdata_oe;

    int tests = 0;
    int fails = 0;

    logic [31:0] mdl [DEPTH];
    logic        p_sel = 1'b0, p_bw = 1'b0, p_gw = 1'b0;
    logic [5:0]  p_addr = '0;
    logic [31:0] p_wd = '0;
    logic [3:0]  p_len = '0;
    logic        exp_drv = 1'b0;
    logic [31:0] exp_dat = '0;

    always #4 clk = ~clk;

    pbw_sram #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .wdata(wdata),
        .lane_en(lane_en), .bw_en(bw_en), .gw_en(gw_en), .oe(oe),
        .rdata(rdata), .rdata_oe(rdata_oe)
    );

    task automatic check(input string tag, input logic [31:0] got_d, input logic [31:0] exp_d,
                         input logic got_o, input logic exp_o);
        tests++;
        if (got_d !== exp_d || got_o !== exp_o) begin
            fails++;
            $display("FAIL %s: rdata=%h oe=%b expected rdata=%h oe=%b", tag, got_d, got_o, exp_d, exp_o);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] m);
        logic [31:0] r = old;
        for (int i = 0; i < 4; i++) if (m[i]) r[8*i +: 8] = nw[8*i +: 8];
        return r;
    endfunction

    task automatic step(input logic s, input logic [5:0] a, input logic [31:0] w,
                        input logic [3:0] l, input logic b, input logic g, input string tag);
        logic wr, rd;
        sel = s; addr = a; wdata = w; lane_en = l; bw_en = b; gw_en = g;
        @(posedge clk);
        wr = p_sel & (p_gw | p_bw);
        rd = p_sel & ~wr;
        exp_drv = rd;
        if (rd) exp_dat = mdl[p_addr];
        if (wr) mdl[p_addr] = merge(mdl[p_addr], p_wd, p_gw ? 4'hF : p_len);
        p_sel = s; p_addr = a; p_wd = w; p_len = l; p_bw = b; p_gw = g;
        @(negedge clk);
        check(tag, rdata, exp_drv ? exp_dat : 32'h0, rdata_oe, exp_drv);
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (2) @(negedge clk);
        check("R1 reset", rdata, 32'h0, rdata_oe, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", rdata, 32'h0, rdata_oe, 1'b0);

        // R3: fill every word with global writes, lane enables deliberately zero
        for (int i = 0; i < DEPTH; i++)
            step(1, 6'(i), 32'hA5000000 ^ (i * 32'h01010101), 4'h0, 1'b0, 1'b1, "R3 fill");
        step(1, 6'd3, 0, 0, 0, 0, "R8 write cycles idle");
        step(1, 6'd3, 0, 0, 0, 0, "R5 read latency R3");

        // R2/R9: partial lanes, then read back
        step(1, 6'd5, 32'h11223344, 4'b0101, 1'b1, 1'b0, "R2 partial write");
        step(1, 6'd5, 0, 0, 0, 0, "R2 idle");
        step(0, 6'd0, 0, 0, 0, 0, "R6 R2 R9 partial readback");
        // R4: all lanes through byte mode
        step(1, 6'd9, 32'hDEADBEEF, 4'hF, 1'b1, 1'b0, "R4 full byte write");
        step(1, 6'd9, 0, 0, 0, 0, "R4 idle");
        step(0, 6'd0, 0, 0, 0, 0, "R4 R6 readback");
        step(0, 6'd0, 0, 0, 0, 0, "R8 deselect stops driving");
        // R2: lane enables without byte-mode enable do nothing
        step(1, 6'd9, 32'h0, 4'hF, 1'b0, 1'b0, "R2 no bw read");
        step(0, 6'd9, 0, 0, 0, 0, "R2 lanes ignored without bw");
        // R10: deselected write attempt
        step(0, 6'd12, 32'hFFFFFFFF, 4'hF, 1'b1, 1'b1, "R10 desel write");
        step(1, 6'd12, 0, 0, 0, 0, "R10 idle");
        step(0, 6'd0, 0, 0, 0, 0, "R10 word unchanged");

        // R7: asynchronous output enable
        step(1, 6'd12, 0, 0, 0, 0, "R7 setup");
        step(1, 6'd12, 0, 0, 0, 0, "R7 driving");
        #1 oe = 1'b0;
        #1 check("R7 oe low", rdata, 32'h0, rdata_oe, 1'b0);
        oe = 1'b1;
        #1 check("R7 oe restored", rdata, mdl[12], rdata_oe, 1'b1);
        step(0, 6'd0, 0, 0, 0, 0, "R8 end of read");

        // random mix, with back-to-back write/read to one address
        for (int n = 0; n < 600; n++) begin
            logic [5:0]  a = 6'($urandom_range(0, 7));
            int          k = $urandom_range(0, 9);
            logic [31:0] w = $urandom;
            logic [3:0]  l = 4'($urandom);
            if (k < 3)       step(1, a, w, l, 1'b1, 1'b0, "R2 R9 random");
            else if (k == 3) step(1, a, w, l, 1'b0, 1'b1, "R3 random");
            else if (k == 4) step(0, a, w, l, 1'b1, 1'($urandom), "R10 R8 random");
            else if (k == 5) begin
                step(1, a, w, l, 1'b1, 1'b0, "R6 pair write");
                step(1, a, 0, 0, 1'b0, 1'b0, "R6 pair read");
            end else         step(1, a, w, l, 1'b0, 1'b0, "R5 random read");
        end
        step(0, 0, 0, 0, 0, 0, "R5 drain");
        step(0, 0, 0, 0, 0, 0, "R8 drain");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule